// File: doc/BRIEF.md
# PPP Control Character Escaper

This block sits between a byte-oriented PPP framer and the serial line. In the transmit direction it examines every payload byte and, when the byte is one that must not appear raw on the line, replaces it with a two-byte escape pair. An escape pair is the escape byte 0x7D followed by the original byte XORed with 0x20. In the receive direction it reverses that mapping. It also drops raw control characters that should only ever arrive escaped, so that CRC checking downstream sees only genuine payload.

A byte needs escaping when any of the following holds:

- it is 0x7D (the escape byte) or 0x7E (the flag);
- it lies in 0x00 to 0x1F and its bit is set in a 32-bit character map;
- it equals one of four user-programmable characters whose enable bit is set.

Both directions use valid/ready byte streams with one registered output stage. Flag generation and CRC are handled elsewhere.

Top module: `ppp_octet_escaper`

## Requirements
- R1: After reset, `tx_out_valid` and `rx_out_valid` are low, and `tx_in_ready` and `rx_in_ready` are high.
- R2: On transmit, the bytes 0x7D and 0x7E always leave as the pair 0x7D, byte^0x20. A raw 0x7E never appears on `tx_out_data`.
- R3: On transmit, a byte b in 0x00..0x1F is escaped when `cfg_accm[b]` is 1 and passed unchanged when that bit is 0. Bytes of 0x20 and above never consult the map.
- R4: On transmit, a byte equal to user character k (`cfg_user_chars[8k+7:8k]`) is escaped when `cfg_user_en[k]` is 1. A user character whose enable bit is 0 has no effect.
- R5: In the cycle after an escapable byte is accepted, `tx_in_ready` is low. Meanwhile `tx_out_valid` is high, carrying 0x7D. Ready stays low until the second byte of the pair has been presented.
- R6: While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_data` holds its value. Transmit output bytes come out in order with none lost or repeated, under any pattern of `tx_out_ready`.
- R7: On receive, a 0x7D is consumed without output, and the byte that follows it is delivered XORed with 0x20.
- R8: On receive, a raw (unescaped) byte that R3 or R4 would have escaped on transmit is discarded. Other raw bytes pass unchanged.
- R9: On receive, 0x7E is always delivered unchanged and cancels any pending escape. When it directly follows a 0x7D, it is delivered with `rx_out_abort` high; otherwise `rx_out_abort` is low.
- R10: While `rx_out_valid` is high and `rx_out_ready` is low, `rx_out_data` and `rx_out_abort` hold. Receive output comes out in order with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accm | input | 32 | Escape map for characters 0x00..0x1F, bit n for character n |
| cfg_user_chars | input | 32 | Four user characters, lane k in bits 8k+7:8k |
| cfg_user_en | input | 4 | Enable per user character lane |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_ready | output | 1 | Transmit payload byte accepted |
| tx_out_data | output | 8 | Line-side transmit byte |
| tx_out_valid | output | 1 | Line-side transmit byte valid |
| tx_out_ready | input | 1 | Line side can take a byte |
| rx_in_data | input | 8 | Line-side received byte |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_ready | output | 1 | Received byte accepted |
| rx_out_data | output | 8 | Unescaped received byte |
| rx_out_valid | output | 1 | Unescaped byte valid |
| rx_out_abort | output | 1 | Flag byte closes an aborted frame |
| rx_out_ready | input | 1 | Downstream can take a byte |

## Verification
The bench targets the edges of the map: character 0x1F at the top of the map, and 0x23, whose low five bits select a set map bit but which must pass because it is above 0x1F. A design that indexed the map without checking the upper bits would wrongly escape 0x23. A disabled user lane holding 0xFF would expose a design that ignores the enable bits.

On receive, the bench sends an escape followed directly by a flag. A design that treated the flag as escaped data would emit 0x5E and lose the frame boundary. The bench also sends an escaped 0x5D, which must come out as a literal 0x7D rather than starting a new escape.

Both directions are run again under a stalling output ready. A design that advanced its pending second byte while stalled would drop or duplicate bytes in the captured stream.

// File: rtl/ppp_octet_escaper.sv
module ppp_octet_escaper #(
  parameter int USER_CHARS = 4,
  parameter int MAP_BITS   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [MAP_BITS-1:0]     cfg_accm,
  input  logic [8*USER_CHARS-1:0] cfg_user_chars,
  input  logic [USER_CHARS-1:0]   cfg_user_en,
  input  logic [7:0]              tx_in_data,
  input  logic                    tx_in_valid,
  output logic                    tx_in_ready,
  output logic [7:0]              tx_out_data,
  output logic                    tx_out_valid,
  input  logic                    tx_out_ready,
  input  logic [7:0]              rx_in_data,
  input  logic                    rx_in_valid,
  output logic                    rx_in_ready,
  output logic [7:0]              rx_out_data,
  output logic                    rx_out_valid,
  output logic                    rx_out_abort,
  input  logic                    rx_out_ready
);
  localparam int IDX_W = $clog2(MAP_BITS);
  localparam logic [7:0] ESC  = 8'h7D;
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] FLIP = 8'h20;

  function automatic logic map_hit(input logic [7:0] b, input logic [MAP_BITS-1:0] m);
    return (b < 8'(MAP_BITS)) && m[b[IDX_W-1:0]];
  endfunction

  logic [USER_CHARS-1:0] tx_user_hit, rx_user_hit;

  for (genvar g = 0; g < USER_CHARS; g++) begin : g_user
    assign tx_user_hit[g] = cfg_user_en[g] && (tx_in_data == cfg_user_chars[8*g +: 8]);
    assign rx_user_hit[g] = cfg_user_en[g] && (rx_in_data == cfg_user_chars[8*g +: 8]);
  end

  // transmit
  logic       tx_pend;
  logic [7:0] tx_pend_data;
  logic       tx_slot, tx_escape;

  assign tx_escape   = (tx_in_data == ESC) || (tx_in_data == FLAG) ||
                       map_hit(tx_in_data, cfg_accm) || (|tx_user_hit);
  assign tx_slot     = !tx_out_valid || tx_out_ready;
  assign tx_in_ready = !tx_pend && tx_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      tx_pend      <= 1'b0;
      tx_pend_data <= '0;
    end else if (tx_slot) begin
      if (tx_pend) begin
        tx_out_valid <= 1'b1;
        tx_out_data  <= tx_pend_data;
        tx_pend      <= 1'b0;
      end else if (tx_in_valid) begin
        tx_out_valid <= 1'b1;
        tx_out_data  <= tx_escape ? ESC : tx_in_data;
        tx_pend      <= tx_escape;
        tx_pend_data <= tx_in_data ^ FLIP;
      end else begin
        tx_out_valid <= 1'b0;
      end
    end
  end

  // receive
  logic rx_esc;
  logic rx_drop;

  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_drop     = map_hit(rx_in_data, cfg_accm) || (|rx_user_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_out_valid <= 1'b0;
      rx_out_abort <= 1'b0;
      rx_out_data  <= '0;
      rx_esc       <= 1'b0;
    end else if (rx_in_ready) begin
      rx_out_valid <= 1'b0;
      rx_out_abort <= 1'b0;
      if (rx_in_valid) begin
        if (rx_in_data == FLAG) begin
          rx_out_valid <= 1'b1;
          rx_out_data  <= FLAG;
          rx_out_abort <= rx_esc;
          rx_esc       <= 1'b0;
        end else if (rx_esc) begin
          rx_out_valid <= 1'b1;
          rx_out_data  <= rx_in_data ^ FLIP;
          rx_esc       <= 1'b0;
        end else if (rx_in_data == ESC) begin
          rx_esc       <= 1'b1;
        end else if (!rx_drop) begin
          rx_out_valid <= 1'b1;
          rx_out_data  <= rx_in_data;
        end
      end
    end
  end
endmodule

// File: rtl/ppp_octet_escaper_sva.sv
module ppp_octet_escaper_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_in_data,
  input logic       tx_in_valid,
  input logic       tx_in_ready,
  input logic [7:0] tx_out_data,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic [7:0] rx_out_data,
  input logic       rx_out_valid,
  input logic       rx_out_abort,
  input logic       rx_out_ready
);
  a_r2_no_raw_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> tx_out_data != 8'h7E);

  a_r5_hold_during_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && (tx_in_data == 8'h7D || tx_in_data == 8'h7E))
      |=> (!tx_in_ready && tx_out_valid && tx_out_data == 8'h7D));

  a_r6_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

  a_r9_abort_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_abort |-> (rx_out_valid && rx_out_data == 8'h7E));

  a_r10_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready)
      |=> (rx_out_valid && $stable(rx_out_data) && $stable(rx_out_abort)));
endmodule

bind ppp_octet_escaper ppp_octet_escaper_sva u_sva (
  .clk(clk), .rst_n(rst_n),
  .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
  .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_out_abort(rx_out_abort),
  .rx_out_ready(rx_out_ready)
);

// File: tb/ppp_octet_escaper_test.sv
`timescale 1ns/1ps
module ppp_octet_escaper_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_accm = 32'h8000_0009;
  logic [31:0] cfg_user_chars = {8'hFF, 8'h91, 8'h13, 8'h11};
  logic [3:0]  cfg_user_en = 4'b0111;
  logic [7:0] tx_in_data = 0, tx_out_data, rx_in_data = 0, rx_out_data;
  logic tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 1;
  logic rx_in_valid = 0, rx_in_ready, rx_out_valid, rx_out_abort, rx_out_ready = 1;
  logic bp = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  ppp_octet_escaper uut (.*);

  // bit 8 = expected escape
  localparam int NTX = 13;
  localparam logic [8:0] TXV [NTX] = '{
    9'h17E, 9'h17D,           // R2
    9'h100, 9'h103, 9'h001,   // R3
    9'h11F, 9'h023,           // R3 edges
    9'h111, 9'h113, 9'h191,   // R4 enabled
    9'h0FF,                   // R4 disabled lane
    9'h020, 9'h041
  };
  localparam int NRXI = 18;
  localparam logic [7:0] RXI [NRXI] = '{
    8'h7E, 8'h41, 8'h7D, 8'h5E, 8'h00, 8'h01, 8'h11, 8'hFF, 8'h7D,
    8'h5D, 8'h7D, 8'h7E, 8'h42, 8'h03, 8'h23, 8'h7E, 8'h13, 8'h7E
  };
  localparam int NRXE = 11;
  localparam logic [8:0] RXE [NRXE] = '{
    9'h07E, 9'h041, 9'h07E, 9'h001, 9'h0FF, 9'h07D,
    9'h17E, 9'h042, 9'h023, 9'h07E, 9'h07E
  };

  logic [7:0] txcap [64];
  logic [8:0] rxcap [64];
  int txn = 0, rxn = 0;

  always @(negedge clk) begin
    if (tx_out_valid && tx_out_ready && txn < 64) begin txcap[txn] = tx_out_data; txn++; end
    if (rx_out_valid && rx_out_ready && rxn < 64) begin rxcap[rxn] = {rx_out_abort, rx_out_data}; rxn++; end
  end

  always @(posedge clk) begin
    cyc++;
    if (bp) begin
      #1 tx_out_ready = (cyc % 3) != 0;
      rx_out_ready = (cyc % 4) != 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_push(logic [7:0] b);
    @(negedge clk);
    tx_in_data = b; tx_in_valid = 1;
    while (!tx_in_ready) @(negedge clk);
    @(posedge clk); #1 tx_in_valid = 0;
  endtask

  task automatic rx_push(logic [7:0] b);
    @(negedge clk);
    rx_in_data = b; rx_in_valid = 1;
    while (!rx_in_ready) @(negedge clk);
    @(posedge clk); #1 rx_in_valid = 0;
  endtask

  task automatic clear_caps();
    @(posedge clk); #2 txn = 0; rxn = 0;
  endtask

  task automatic tx_run(string tag);
    int k;
    clear_caps();
    for (int i = 0; i < NTX; i++) tx_push(TXV[i][7:0]);
    repeat (30) @(negedge clk);
    k = 0;
    for (int i = 0; i < NTX; i++) begin
      if (TXV[i][8]) begin
        chk({tag, " R2/R3/R4 escape byte"}, txcap[k], 8'h7D);
        chk({tag, " R2/R3/R4 flipped byte"}, txcap[k+1], TXV[i][7:0] ^ 8'h20);
        k += 2;
      end else begin
        chk({tag, " R3/R4 passthrough"}, txcap[k], TXV[i][7:0]);
        k += 1;
      end
    end
    chk({tag, " R6 tx count"}, txn, k);
  endtask

  task automatic rx_run(string tag);
    clear_caps();
    for (int i = 0; i < NRXI; i++) rx_push(RXI[i]);
    repeat (30) @(negedge clk);
    chk({tag, " R10 rx count"}, rxn, NRXE);
    for (int i = 0; i < NRXE; i++)
      chk({tag, " R7/R8/R9 rx byte"}, rxcap[i], RXE[i]);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 tx_out_valid", tx_out_valid, 0);
    chk("R1 rx_out_valid", rx_out_valid, 0);
    chk("R1 tx_in_ready", tx_in_ready, 1);
    chk("R1 rx_in_ready", rx_in_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    tx_run("free");
    rx_run("free");

    // R5: ready drops while second byte is pending
    clear_caps();
    @(negedge clk); tx_in_data = 8'h7E; tx_in_valid = 1;
    @(posedge clk); #1 tx_in_valid = 0;
    @(negedge clk);
    chk("R5 ready low during pair", tx_in_ready, 0);
    chk("R5 first byte", tx_out_data, 8'h7D);
    @(negedge clk);
    chk("R5 ready back", tx_in_ready, 1);
    chk("R5 second byte", tx_out_data, 8'h5E);

    // R6/R10 under backpressure
    bp = 1;
    tx_run("bp");
    rx_run("bp");
    bp = 0;
    @(posedge clk); #1 tx_out_ready = 1; rx_out_ready = 1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule